// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a serial link to a multi-channel digital-to-analog converter. It takes one 24-bit word at a time through a valid/ready handshake. For each word it sends one framed serial write: it drops an active-low chip-enable, then the frame strobe, then clocks the word out most-significant bit first, and can then pulse a load strobe that updates the converter outputs. Every minimum gap between these edges is a parameter counted in system-clock cycles, with each value rounded up from its nanosecond limit.

Two sets of clock-phase and strobe-high-time limits are built in, one for a low supply range and one for a high supply range. A select input, sampled when the word is accepted, chooses between them. An abort input ends a frame early. It takes effect only while enough of the frame is left that the receiver treats the early strobe rise as a cancel, never in the window just before the last falling clock edge.

Top module: `dac_write_seq`

## Requirements
- R1: Out of reset `dacSclk`=1, `dacSyncN`=1, `dacEnableN`=1, `dacLdac`=0, `busy`=0 and `inReady`=1.
- R2: `inReady` is the inverse of `busy`. A word is taken only on a clock edge with `inValid` and `inReady` both high. A word held valid while busy is not taken until the sequencer is idle again.
- R3: `dacEnableN` falls on the accept edge. `dacSyncN` falls ENA_SETUP cycles later, and it never falls while `dacEnableN` is high.
- R4: While `dacSyncN` is low, `dacSclk` starts high and alternates between a high phase and a low phase of the selected lengths. The 24th falling edge ends the shifting.
- R5: `dacSdo` carries bit 23 of the word first and bit 0 last. Inside a frame it changes only on rising `dacSclk` edges, so each bit is steady around the falling edge that samples it.
- R6: Whenever `dacSyncN` is high, `dacSclk` is high.
- R7: `rangeHigh`=1 at the accept edge selects the high-range phase lengths and strobe-high time, and 0 selects the low-range set. Changing `rangeHigh` during a transfer has no effect on that transfer.
- R8: `dacSyncN` rises one low-phase length after the 24th falling edge. The sequencer stays busy until at least SYNC_GAP cycles after that edge and at least the selected strobe-high time after the `dacSyncN` rise.
- R9: With `inLdac`=1 at accept, `dacLdac` (active high) rises LDAC_DELAY cycles after the 24th falling edge and stays high LDAC_WIDTH cycles. `dacEnableN` then rises LDAC_DELAY+max(LDAC_TO_ENA, LDAC_WIDTH) cycles after that edge. With `inLdac`=0 no pulse occurs and `dacEnableN` rises ENA_HOLD cycles after the 24th falling edge.
- R10: `abortReq` sampled high during shifting, after fewer than 23 falling edges, raises `dacSyncN` and `dacSclk` on that edge. No load pulse follows, `dacEnableN` rises ENA_HOLD cycles later, and `busy` drops max(SYNC_GAP, strobe-high time, ENA_HOLD) cycles later.
- R11: `abortReq` is ignored when idle, before `dacSyncN` falls, and once 23 or more falling edges have occurred. In those cases the frame completes as normal.
- R12: `busy` is high from the accept edge until every post-frame gap has elapsed. While `busy` is low, `dacEnableN` and `dacSyncN` are high and `dacLdac` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Word offered |
| inReady | output | 1 | Sequencer can take a word |
| inWord | input | 24 | Word to send, bit 23 first |
| inLdac | input | 1 | Pulse the load strobe after this frame |
| rangeHigh | input | 1 | 1 = high supply range timing, 0 = low |
| abortReq | input | 1 | Request to cancel the frame in flight |
| busy | output | 1 | Transfer or post-frame gap in progress |
| dacSclk | output | 1 | Serial clock, idles high |
| dacSyncN | output | 1 | Frame strobe, active low |
| dacSdo | output | 1 | Serial data |
| dacEnableN | output | 1 | Device enable, active low |
| dacLdac | output | 1 | Output load pulse, active high |

## Verification
A wrong phase or bit counter in this block shows at the pins within one serial-clock phase. The clock edge lands a cycle early or late, or the data bit changes between rising edges, and a per-cycle comparison against a timestamp model catches it on that same cycle. A wrong post-frame timer is slower to show: the enable or load edge moves, or `busy` drops early. That is seen at the first edge that moves, at the latest when the next word is taken too soon. A wrong abort window only shows when an abort lands right on the 22nd or 23rd falling edge, so the bench aims aborts at exactly those two points.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef struct packed {
    logic load;
    logic shift;
    logic sclkFall;
    logic sclkRise;
    logic syncFall;
    logic syncRise;
    logic enaFall;
    logic enaRise;
    logic ldacSet;
    logic ldacClr;
  } dwsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_POST  = 2'd3
  } dwsState_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int SCLK_HIGH_LO = 2,
  parameter int SCLK_LOW_LO  = 2,
  parameter int SCLK_HIGH_HI = 2,
  parameter int SCLK_LOW_HI  = 1,
  parameter int SYNC_HIGH_LO = 4,
  parameter int SYNC_HIGH_HI = 2,
  parameter int ENA_SETUP    = 2,
  parameter int ENA_HOLD     = 1,
  parameter int SYNC_GAP     = 13,
  parameter int LDAC_DELAY   = 5,
  parameter int LDAC_WIDTH   = 1,
  parameter int LDAC_TO_ENA  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLdac,
  input  logic       rangeHigh,
  input  logic       abortReq,
  output logic       inReady,
  output logic       busy,
  output dwsStrobe_t stb
);

  // Offsets counted from the 24th falling edge (or from the abort edge).
  localparam int LDAC_ENA   = LDAC_DELAY + maxOf(LDAC_TO_ENA, LDAC_WIDTH);
  localparam int DONE_LO_LD = maxOf(maxOf(SYNC_GAP, SCLK_LOW_LO + SYNC_HIGH_LO),
                                    maxOf(LDAC_ENA, LDAC_DELAY + LDAC_WIDTH));
  localparam int DONE_HI_LD = maxOf(maxOf(SYNC_GAP, SCLK_LOW_HI + SYNC_HIGH_HI),
                                    maxOf(LDAC_ENA, LDAC_DELAY + LDAC_WIDTH));
  localparam int DONE_LO_NL = maxOf(maxOf(SYNC_GAP, SCLK_LOW_LO + SYNC_HIGH_LO), ENA_HOLD);
  localparam int DONE_HI_NL = maxOf(maxOf(SYNC_GAP, SCLK_LOW_HI + SYNC_HIGH_HI), ENA_HOLD);
  localparam int DONE_AB_LO = maxOf(maxOf(SYNC_GAP, SYNC_HIGH_LO), ENA_HOLD);
  localparam int DONE_AB_HI = maxOf(maxOf(SYNC_GAP, SYNC_HIGH_HI), ENA_HOLD);
  localparam int MAX_SPAN   = maxOf(maxOf(DONE_LO_LD, DONE_HI_LD),
                                    maxOf(ENA_SETUP, maxOf(SCLK_HIGH_LO, SCLK_HIGH_HI)));
  localparam int TW         = $clog2(MAX_SPAN + 1) + 1;
  localparam int FW         = $clog2(WORD_W + 1);

  localparam logic [TW-1:0] LEAD_END   = TW'(ENA_SETUP - 1);
  localparam logic [TW-1:0] HI_END_LO  = TW'(SCLK_HIGH_LO - 1);
  localparam logic [TW-1:0] HI_END_HI  = TW'(SCLK_HIGH_HI - 1);
  localparam logic [TW-1:0] LO_END_LO  = TW'(SCLK_LOW_LO - 1);
  localparam logic [TW-1:0] LO_END_HI  = TW'(SCLK_LOW_HI - 1);
  localparam logic [TW-1:0] LDON_END   = TW'(LDAC_DELAY - 1);
  localparam logic [TW-1:0] LDOFF_END  = TW'(LDAC_DELAY + LDAC_WIDTH - 1);
  localparam logic [TW-1:0] ENA_LD_END = TW'(LDAC_ENA - 1);
  localparam logic [TW-1:0] ENA_NL_END = TW'(ENA_HOLD - 1);
  localparam logic [FW-1:0] LAST_FALL  = FW'(WORD_W - 1);
  localparam logic [FW-1:0] ABORT_LIM  = FW'(WORD_W - 1);

  dwsState_t     state, stateNx;
  logic [TW-1:0] tmr, tmrNx, pc, pcNx;
  logic [FW-1:0] fallCnt, fallNx;
  logic          phHigh, phNx, rngHi, rngNx, ldReq, ldNx, aborted, abNx;
  logic [TW-1:0] hiEnd, loEnd, enaEnd, doneEnd;

  assign inReady = (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  // Timing set chosen by the range captured at accept.
  always_comb begin
    hiEnd  = rngHi ? HI_END_HI : HI_END_LO;
    loEnd  = rngHi ? LO_END_HI : LO_END_LO;
    enaEnd = (!aborted && ldReq) ? ENA_LD_END : ENA_NL_END;
    if (aborted)    doneEnd = TW'((rngHi ? DONE_AB_HI : DONE_AB_LO) - 1);
    else if (ldReq) doneEnd = TW'((rngHi ? DONE_HI_LD : DONE_LO_LD) - 1);
    else            doneEnd = TW'((rngHi ? DONE_HI_NL : DONE_LO_NL) - 1);
  end

  always_comb begin
    stb     = '0;
    stateNx = state;
    tmrNx   = tmr;
    pcNx    = pc;
    phNx    = phHigh;
    fallNx  = fallCnt;
    rngNx   = rngHi;
    ldNx    = ldReq;
    abNx    = aborted;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          stb.load    = 1'b1;
          stb.enaFall = 1'b1;
          rngNx       = rangeHigh;
          ldNx        = inLdac;
          abNx        = 1'b0;
          tmrNx       = '0;
          stateNx     = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (tmr == LEAD_END) begin
          stb.syncFall = 1'b1;
          pcNx         = '0;
          phNx         = 1'b1;
          fallNx       = '0;
          stateNx      = ST_SHIFT;
        end else begin
          tmrNx = tmr + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (abortReq && (fallCnt < ABORT_LIM)) begin
          stb.syncRise = 1'b1;
          stb.sclkRise = 1'b1;
          abNx         = 1'b1;
          tmrNx        = '0;
          stateNx      = ST_POST;
        end else if (phHigh) begin
          if (pc == hiEnd) begin
            stb.sclkFall = 1'b1;
            fallNx       = fallCnt + 1'b1;
            pcNx         = '0;
            phNx         = 1'b0;
            if (fallCnt == LAST_FALL) begin
              tmrNx   = '0;
              stateNx = ST_POST;
            end
          end else begin
            pcNx = pc + 1'b1;
          end
        end else begin
          if (pc == loEnd) begin
            stb.sclkRise = 1'b1;
            stb.shift    = 1'b1;
            pcNx         = '0;
            phNx         = 1'b1;
          end else begin
            pcNx = pc + 1'b1;
          end
        end
      end
      ST_POST: begin
        tmrNx = tmr + 1'b1;
        if (!aborted && tmr == loEnd) begin
          stb.sclkRise = 1'b1;
          stb.syncRise = 1'b1;
        end
        if (!aborted && ldReq && tmr == LDON_END)  stb.ldacSet = 1'b1;
        if (!aborted && ldReq && tmr == LDOFF_END) stb.ldacClr = 1'b1;
        if (tmr == enaEnd) stb.enaRise = 1'b1;
        if (tmr == doneEnd) stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      pc      <= '0;
      phHigh  <= 1'b1;
      fallCnt <= '0;
      rngHi   <= 1'b0;
      ldReq   <= 1'b0;
      aborted <= 1'b0;
    end else begin
      state   <= stateNx;
      tmr     <= tmrNx;
      pc      <= pcNx;
      phHigh  <= phNx;
      fallCnt <= fallNx;
      rngHi   <= rngNx;
      ldReq   <= ldNx;
      aborted <= abNx;
    end
  end

  // R2: an accepted word makes the sequencer busy and closes the handshake.
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (busy && !inReady));

  // R11: no abort is honoured once the 23rd falling edge has gone by.
  assert_late_abort_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && fallCnt >= ABORT_LIM) |=> !aborted);

endmodule

// File: rtl/dws_datapath.sv
module dws_datapath
  import dws_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwsStrobe_t        stb,
  input  logic [WORD_W-1:0] inWord,
  output logic              sclk,
  output logic              syncN,
  output logic              enableN,
  output logic              ldac,
  output logic              sdo
);

  logic [WORD_W-1:0] shReg;

  assign sdo = shReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      sclk    <= 1'b1;
      syncN   <= 1'b1;
      enableN <= 1'b1;
      ldac    <= 1'b0;
    end else begin
      if (stb.load)       shReg <= inWord;
      else if (stb.shift) shReg <= {shReg[WORD_W-2:0], 1'b0};
      if (stb.sclkFall)      sclk <= 1'b0;
      else if (stb.sclkRise) sclk <= 1'b1;
      if (stb.syncFall)      syncN <= 1'b0;
      else if (stb.syncRise) syncN <= 1'b1;
      if (stb.enaFall)       enableN <= 1'b0;
      else if (stb.enaRise)  enableN <= 1'b1;
      if (stb.ldacSet)       ldac <= 1'b1;
      else if (stb.ldacClr)  ldac <= 1'b0;
    end
  end

  // R6: the serial clock idles high outside a frame.
  assert_sclk_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    syncN |-> sclk);

  // R5: inside a frame the data bit moves only with a rising clock edge.
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!syncN && !$past(syncN) && !$rose(sclk)) |-> $stable(sdo));

  // R3: the frame strobe only falls after enable has already been low.
  assert_enable_before_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncN) |-> (!enableN && $past(!enableN)));

  // R9: the load pulse lies inside the enable window.
  assert_ldac_in_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    ldac |-> !enableN);

endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq
  import dws_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int SCLK_HIGH_LO = 2,
  parameter int SCLK_LOW_LO  = 2,
  parameter int SCLK_HIGH_HI = 2,
  parameter int SCLK_LOW_HI  = 1,
  parameter int SYNC_HIGH_LO = 4,
  parameter int SYNC_HIGH_HI = 2,
  parameter int ENA_SETUP    = 2,
  parameter int ENA_HOLD     = 1,
  parameter int SYNC_GAP     = 13,
  parameter int LDAC_DELAY   = 5,
  parameter int LDAC_WIDTH   = 1,
  parameter int LDAC_TO_ENA  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inLdac,
  input  logic              rangeHigh,
  input  logic              abortReq,
  output logic              busy,
  output logic              dacSclk,
  output logic              dacSyncN,
  output logic              dacSdo,
  output logic              dacEnableN,
  output logic              dacLdac
);

  dwsStrobe_t stb;

  dws_ctrl #(
    .WORD_W(WORD_W), .SCLK_HIGH_LO(SCLK_HIGH_LO), .SCLK_LOW_LO(SCLK_LOW_LO),
    .SCLK_HIGH_HI(SCLK_HIGH_HI), .SCLK_LOW_HI(SCLK_LOW_HI),
    .SYNC_HIGH_LO(SYNC_HIGH_LO), .SYNC_HIGH_HI(SYNC_HIGH_HI),
    .ENA_SETUP(ENA_SETUP), .ENA_HOLD(ENA_HOLD), .SYNC_GAP(SYNC_GAP),
    .LDAC_DELAY(LDAC_DELAY), .LDAC_WIDTH(LDAC_WIDTH), .LDAC_TO_ENA(LDAC_TO_ENA)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLdac(inLdac),
    .rangeHigh(rangeHigh), .abortReq(abortReq), .inReady(inReady),
    .busy(busy), .stb(stb)
  );

  dws_datapath #(.WORD_W(WORD_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .inWord(inWord),
    .sclk(dacSclk), .syncN(dacSyncN), .enableN(dacEnableN),
    .ldac(dacLdac), .sdo(dacSdo)
  );

  // R12: when idle every device-side strobe is at rest.
  assert_idle_outputs_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (dacEnableN && dacSyncN && !dacLdac && dacSclk));

endmodule

// File: tb/test_dac_write_seq.sv
module test_dac_write_seq;

  localparam int W   = 24;
  localparam int HLO = 2, LLO = 2, HHI = 2, LHI = 1;
  localparam int SHLO = 4, SHHI = 2;
  localparam int ES = 2, EH = 1, SG = 13, LD = 5, LW = 1, LTE = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLdac = 1'b0, rangeHigh = 1'b0, abortReq = 1'b0;
  logic [W-1:0] inWord = '0;
  logic inReady, busy, dacSclk, dacSyncN, dacSdo, dacEnableN, dacLdac;

  int nChecks = 0, nFail = 0, cyc = 0;
  string scen = "R1";

  always #5 clk = ~clk;

  dac_write_seq i_dac_write_seq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .inLdac(inLdac), .rangeHigh(rangeHigh), .abortReq(abortReq), .busy(busy),
    .dacSclk(dacSclk), .dacSyncN(dacSyncN), .dacSdo(dacSdo),
    .dacEnableN(dacEnableN), .dacLdac(dacLdac)
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s/%s %s actual=%0b expected=%0b cycle=%0d", scen, req, name, act, exp, cyc);
    end
  endtask

  // Reference model: timestamps per transfer, outputs derived per edge index.
  int  E = 0, A = 0, S = 0, F = 0, B = 0, H = 0, L = 0, shg = 0, enaT = 0, D = 0;
  bit  act = 0, abd = 0, ld = 0;
  logic [W-1:0] w = '0;

  function automatic int fallsTo(input int e);
    int c = 0;
    for (int k = 1; k <= W; k++) if (S + k*H + (k-1)*L <= e) c++;
    return c;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      E = 0;
    end else begin
      bit exBusy, exEnN, exSyncN, exSclk, exLdac;
      int fEnd;
      fEnd    = abd ? B : F + L;
      exBusy  = act && E >= A && E < D;
      exEnN   = !(act && E >= A && E < enaT);
      exSyncN = !(act && E >= S && E < fEnd);
      exSclk  = exSyncN ? 1'b1 : (((E - S) % (H + L)) < H);
      exLdac  = act && !abd && ld && E >= F + LD && E < F + LD + LW;
      chk("R2", "inReady", inReady, !exBusy);
      chk("R12", "busy", busy, exBusy);
      chk("R3", "dacEnableN", dacEnableN, exEnN);
      chk("R8", "dacSyncN", dacSyncN, exSyncN);
      chk(exSyncN ? "R6" : "R4", "dacSclk", dacSclk, exSclk);
      chk("R9", "dacLdac", dacLdac, exLdac);
      if (!exSyncN) chk("R5", "dacSdo", dacSdo, w[W-1-((E - S) / (H + L))]);
      // R10: abort honoured only during shifting with fewer than 23 falls.
      if (act && !abd && abortReq && E >= S && E < F && fallsTo(E) < W - 1) begin
        abd  = 1;
        B    = E + 1;
        enaT = B + EH;
        D    = B + mx(mx(SG, shg), EH);
      end
      if (!exBusy && inValid) begin
        act = 1; abd = 0; A = E + 1; w = inWord; ld = inLdac;
        H   = rangeHigh ? HHI : HLO;
        L   = rangeHigh ? LHI : LLO;
        shg = rangeHigh ? SHHI : SHLO;
        S   = A + ES;
        F   = S + W*(H + L) - L;
        enaT = ld ? F + LD + mx(LTE, LW) : F + EH;
        D    = F + mx(mx(SG, L + shg), ld ? mx(LD + mx(LTE, LW), LD + LW) : EH);
      end
      E++;
    end
  end

  task automatic send(input logic [W-1:0] wd, input logic ldq, input logic rng, input bit keep);
    inWord = wd; inLdac = ldq; rangeHigh = rng; inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk); #2;
    if (!keep) inValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    @(posedge clk); #2;
  endtask

  task automatic abortAfterFalls(input int n);
    repeat (n) @(negedge dacSclk);
    #2 abortReq = 1'b1;
    @(posedge clk); #2 abortReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset values compared by the model on the first cycles.
    repeat (3) @(posedge clk); #2;

    scen = "R4";  // low range, load pulse requested (R9)
    send(24'hA5C3F0, 1'b1, 1'b0, 0);
    waitIdle();

    scen = "R7";  // high range, range input flips mid-transfer
    send(24'h5A0F3C, 1'b0, 1'b1, 0);
    repeat (10) @(posedge clk);
    #2 rangeHigh = 1'b0;
    waitIdle();

    scen = "R2";  // word held valid while busy, then taken when idle
    send(24'hFFFFFF, 1'b1, 1'b1, 1);
    send(24'h000001, 1'b0, 1'b0, 0);
    waitIdle();

    scen = "R10"; // early abort after 5 falls
    send(24'h123456, 1'b1, 1'b0, 0);
    abortAfterFalls(5);
    waitIdle();

    scen = "R10"; // last honoured point: right after the 22nd fall
    send(24'h800001, 1'b0, 1'b1, 0);
    abortAfterFalls(22);
    waitIdle();

    scen = "R11"; // ignored right after the 23rd fall
    send(24'hC0FFEE, 1'b1, 1'b1, 0);
    abortAfterFalls(23);
    waitIdle();

    scen = "R11"; // ignored during enable lead-in and while idle
    send(24'h3C3C3C, 1'b0, 1'b0, 0);
    #0 abortReq = 1'b1;
    @(posedge clk); #2 abortReq = 1'b0;
    waitIdle();
    abortReq = 1'b1;
    repeat (3) @(posedge clk);
    #2 abortReq = 1'b0;
    repeat (5) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule